// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block gives two independent ports a set of eight hardware lock flags. Software on either side uses them to claim shared resources. A port claims a flag by writing a zero to it. It then reads the flag back: a zero means the port holds the flag, and a one means the other side holds it or it is still being contested. Writing a one gives the flag up or withdraws a claim that is still waiting.

Ownership is exclusive. While one side holds a flag, the two ports see complementary values at that address. A claim made by the non-holder is remembered. The moment the holder lets go, that claim turns into ownership, with no retry needed. When both sides claim a free flag in the same cycle, the left side wins and the right side's claim waits.

Each port has its own output register. A read copies the flag value onto every bit of that register, and the register keeps that value until the same port reads again.

Top module: `sem_bank`

## Requirements
- R1: After reset, every flag is free with no claims waiting: both ports read 1 at every address, and both data outputs are all ones.
- R2: A write of data 0 to a free flag makes the writing port its owner; that port then reads 0 and the other port reads 1 at that address.
- R3: While a port owns a flag, writes from the other port do not change the owner: the owner keeps reading 0.
- R4: When the owner writes 1 and the other port has no claim waiting, both ports read 1 at that address.
- R5: If the non-owner wrote 0 while the flag was owned, it becomes the owner in the same cycle that the owner writes 1: it reads 0 and the former owner reads 1.
- R6: A port that writes 1 while its claim is waiting withdraws the claim; a later release by the owner leaves the flag free.
- R7: When both ports write 0 to the same free flag in the same clock cycle, the left port becomes owner and the right port's claim waits.
- R8: The eight flags, selected by the 3-bit address, are independent; an access to one never changes another.
- R9: A read (select and output enable high, write strobe low) loads the addressed flag value, 0 for owned by this port and 1 otherwise, into every bit of that port's output register, visible after the capturing clock edge.
- R10: A port's output register changes only on that port's own read, whatever the other port does to the flag.
- R11: A write strobe with the port select low has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lSel | input | 1 | Left port flag select |
| lAddr | input | 3 | Left port flag index |
| lWrEn | input | 1 | Left port write strobe |
| lOutEn | input | 1 | Left port output enable (read) |
| lDin | input | 1 | Left port write value (0 claim, 1 release) |
| lDout | output | DATA_W | Left port registered read data |
| rSel | input | 1 | Right port flag select |
| rAddr | input | 3 | Right port flag index |
| rWrEn | input | 1 | Right port write strobe |
| rOutEn | input | 1 | Right port output enable (read) |
| rDin | input | 1 | Right port write value (0 claim, 1 release) |
| rDout | output | DATA_W | Right port registered read data |

## Verification
The assertions take all port inputs to be synchronous to the clock and free of X once reset is released. They also treat a cycle with select, write strobe and output enable all high as a write only. The stimulus drives inputs on the falling edge, keeps every strobe at a known 0 outside its cycle, and never asserts a write and a read on the same port in one cycle. Release contention and the same-cycle tie are therefore always resolved at a clean rising edge.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int SEM_ADDR_W = 3;
  localparam int SEM_COUNT  = 1 << SEM_ADDR_W;

  typedef struct packed {
    logic [SEM_COUNT-1:0]  wrL;
    logic [SEM_COUNT-1:0]  wrR;
    logic                  valL;
    logic                  valR;
    logic                  rdL;
    logic                  rdR;
    logic [SEM_ADDR_W-1:0] rdAddrL;
    logic [SEM_ADDR_W-1:0] rdAddrR;
  } semStrobe_t;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
(
  input  logic                  lSel,
  input  logic [SEM_ADDR_W-1:0] lAddr,
  input  logic                  lWrEn,
  input  logic                  lOutEn,
  input  logic                  lDin,
  input  logic                  rSel,
  input  logic [SEM_ADDR_W-1:0] rAddr,
  input  logic                  rWrEn,
  input  logic                  rOutEn,
  input  logic                  rDin,
  output semStrobe_t            strobe
);
  logic lWrite, rWrite;

  assign lWrite = lSel && lWrEn;
  assign rWrite = rSel && rWrEn;

  always_comb begin
    strobe = '0;
    for (int i = 0; i < SEM_COUNT; i++) begin
      strobe.wrL[i] = lWrite && (lAddr == SEM_ADDR_W'(i));
      strobe.wrR[i] = rWrite && (rAddr == SEM_ADDR_W'(i));
    end
    strobe.valL    = lDin;
    strobe.valR    = rDin;
    // a write takes precedence over a read on the same port
    strobe.rdL     = lSel && lOutEn && !lWrEn;
    strobe.rdR     = rSel && rOutEn && !rWrEn;
    strobe.rdAddrL = lAddr;
    strobe.rdAddrR = rAddr;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell (
  input  logic clk,
  input  logic rstN,
  input  logic wrL,
  input  logic valL,
  input  logic wrR,
  input  logic valR,
  output logic ownL,
  output logic ownR
);
  logic reqL, reqR;
  logic nReqL, nReqR;
  logic nOwnL, nOwnR;

  // a claim is held while the port's last write was 0
  assign nReqL = wrL ? ~valL : reqL;
  assign nReqR = wrR ? ~valR : reqR;

  always_comb begin
    nOwnL = 1'b0;
    nOwnR = 1'b0;
    if (ownL && nReqL)      nOwnL = 1'b1; // holder keeps it
    else if (ownR && nReqR) nOwnR = 1'b1;
    else if (nReqL)         nOwnL = 1'b1; // left wins ties and hand-offs
    else if (nReqR)         nOwnR = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqL <= 1'b0;
      reqR <= 1'b0;
      ownL <= 1'b0;
      ownR <= 1'b0;
    end else begin
      reqL <= nReqL;
      reqR <= nReqR;
      ownL <= nOwnL;
      ownR <= nOwnR;
    end
  end
endmodule

// File: rtl/sem_dp.sv
module sem_dp
  import sem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  semStrobe_t           strobe,
  output logic [SEM_COUNT-1:0] ownL,
  output logic [SEM_COUNT-1:0] ownR,
  output logic [DATA_W-1:0]    lDout,
  output logic [DATA_W-1:0]    rDout
);
  for (genvar g = 0; g < SEM_COUNT; g++) begin : g_cell
    sem_cell u_cell (
      .clk  (clk),
      .rstN (rstN),
      .wrL  (strobe.wrL[g]),
      .valL (strobe.valL),
      .wrR  (strobe.wrR[g]),
      .valR (strobe.valR),
      .ownL (ownL[g]),
      .ownR (ownR[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lDout <= '1;
      rDout <= '1;
    end else begin
      if (strobe.rdL) lDout <= {DATA_W{~ownL[strobe.rdAddrL]}};
      if (strobe.rdR) rDout <= {DATA_W{~ownR[strobe.rdAddrR]}};
    end
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lSel,
  input  logic [SEM_ADDR_W-1:0] lAddr,
  input  logic                  lWrEn,
  input  logic                  lOutEn,
  input  logic                  lDin,
  output logic [DATA_W-1:0]     lDout,
  input  logic                  rSel,
  input  logic [SEM_ADDR_W-1:0] rAddr,
  input  logic                  rWrEn,
  input  logic                  rOutEn,
  input  logic                  rDin,
  output logic [DATA_W-1:0]     rDout
);
  semStrobe_t           strobe;
  logic [SEM_COUNT-1:0] ownL;
  logic [SEM_COUNT-1:0] ownR;

  sem_ctrl u_ctrl (
    .lSel   (lSel),
    .lAddr  (lAddr),
    .lWrEn  (lWrEn),
    .lOutEn (lOutEn),
    .lDin   (lDin),
    .rSel   (rSel),
    .rAddr  (rAddr),
    .rWrEn  (rWrEn),
    .rOutEn (rOutEn),
    .rDin   (rDin),
    .strobe (strobe)
  );

  sem_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .ownL   (ownL),
    .ownR   (ownR),
    .lDout  (lDout),
    .rDout  (rDout)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
  import sem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 lSel,
  input logic                 lWrEn,
  input logic                 lOutEn,
  input logic                 rSel,
  input logic                 rWrEn,
  input logic                 rOutEn,
  input logic [SEM_COUNT-1:0] ownL,
  input logic [SEM_COUNT-1:0] ownR,
  input logic [DATA_W-1:0]    lDout,
  input logic [DATA_W-1:0]    rDout
);
  // R1
  reset_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ownL == '0 && ownR == '0));

  // R2
  exclusive_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ownL & ownR) == '0);

  // R3
  left_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lSel && lWrEn) |=> (($past(ownL) & ~ownL) == '0));

  // R3
  right_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rSel && rWrEn) |=> (($past(ownR) & ~ownR) == '0));

  // R9
  left_replicate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lDout == '0) || (lDout == '1));

  // R9
  right_replicate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rDout == '0) || (rDout == '1));

  // R10
  left_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lSel && lOutEn && !lWrEn) |=> $stable(lDout));

  // R10
  right_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rSel && rOutEn && !rWrEn) |=> $stable(rDout));
endmodule

bind sem_bank sem_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .lSel   (lSel),
  .lWrEn  (lWrEn),
  .lOutEn (lOutEn),
  .rSel   (rSel),
  .rWrEn  (rWrEn),
  .rOutEn (rOutEn),
  .ownL   (ownL),
  .ownR   (ownR),
  .lDout  (lDout),
  .rDout  (rDout)
);

// File: tb/sim_sem_bank.sv
`timescale 1ns/1ps
module sim_sem_bank;
  localparam int W = 16;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lSel = 0, lWrEn = 0, lOutEn = 0, lDin = 0;
  logic rSel = 0, rWrEn = 0, rOutEn = 0, rDin = 0;
  logic [2:0] lAddr = '0, rAddr = '0;
  logic [W-1:0] lDout, rDout;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sem_bank #(.DATA_W(W)) u0 (
    .clk(clk), .rstN(rstN),
    .lSel(lSel), .lAddr(lAddr), .lWrEn(lWrEn), .lOutEn(lOutEn), .lDin(lDin), .lDout(lDout),
    .rSel(rSel), .rAddr(rAddr), .rWrEn(rWrEn), .rOutEn(rOutEn), .rDin(rDin), .rDout(rDout)
  );

  // fields: lW lA[3] lD | rW rA[3] rD | checkAddr[3] | expL expR
  localparam logic [14:0] VEC [NVEC] = '{
    15'b1_000_0_0_000_0_000_0_1, // R2 left claims free flag 0
    15'b0_000_0_1_000_1_000_0_1, // R3 right release attempt ignored
    15'b0_000_0_1_000_0_000_0_1, // R3 right claim waits
    15'b1_000_1_0_000_0_000_1_0, // R5 hand-off to right
    15'b0_000_0_1_000_1_000_1_1, // R4 release, nothing waiting
    15'b1_001_0_1_001_0_001_0_1, // R7 tie on flag 1, left wins
    15'b1_001_1_0_000_0_001_1_0, // R7 right's waiting claim takes over
    15'b0_000_0_1_001_1_001_1_1, // R4 free again
    15'b0_000_0_1_010_0_010_1_0, // R2 right claims flag 2
    15'b1_010_0_1_011_0_010_1_0, // R8 left waits on 2, right claims 3
    15'b0_000_0_0_000_0_011_1_0, // R8 flag 3 held by right
    15'b1_010_1_0_000_0_010_1_0, // R6 left withdraws claim
    15'b0_000_0_1_010_1_010_1_1, // R6 release leaves flag 2 free
    15'b0_000_0_0_000_0_000_1_1  // R8 flag 0 untouched
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic lw, input logic [2:0] la, input logic ld,
                         input logic rw, input logic [2:0] ra, input logic rd);
    @(negedge clk);
    lSel = lw; lWrEn = lw; lAddr = la; lDin = ld;
    rSel = rw; rWrEn = rw; rAddr = ra; rDin = rd;
    @(negedge clk);
    lSel = 0; lWrEn = 0; rSel = 0; rWrEn = 0;
  endtask

  task automatic readBoth(input logic [2:0] a);
    @(negedge clk);
    lSel = 1; lOutEn = 1; lAddr = a;
    rSel = 1; rOutEn = 1; rAddr = a;
    @(negedge clk);
    lSel = 0; lOutEn = 0; rSel = 0; rOutEn = 0;
  endtask

  task automatic readLeft(input logic [2:0] a);
    @(negedge clk);
    lSel = 1; lOutEn = 1; lAddr = a;
    @(negedge clk);
    lSel = 0; lOutEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state on outputs and on a read
    check("R1 lDout after reset", lDout, '1);
    readBoth(3'd5);
    check("R1 flag 5 left", lDout, '1);
    check("R1 flag 5 right", rDout, '1);

    for (int i = 0; i < NVEC; i++) begin
      logic [14:0] v;
      v = VEC[i];
      doWrite(v[14], v[13:11], v[10], v[9], v[8:6], v[5]);
      readBoth(v[4:2]);
      // R9 every bit carries the flag value
      check($sformatf("vector %0d left (R9)", i), lDout, {W{v[1]}});
      check($sformatf("vector %0d right (R9)", i), rDout, {W{v[0]}});
    end

    // R10 output register holds across the other side's changes
    readLeft(3'd3);
    check("R10 left sees flag 3 taken", lDout, '1);
    doWrite(1'b1, 3'd3, 1'b0, 1'b1, 3'd3, 1'b1);
    check("R10 left held without read", lDout, '1);
    check("R10 right held without read", rDout, '1);
    readLeft(3'd3);
    check("R10 left new read owns 3", lDout, '0);

    // R11 write strobe without select is ignored
    @(negedge clk);
    lSel = 0; lWrEn = 1; lAddr = 3'd3; lDin = 1;
    rSel = 0; rWrEn = 1; rAddr = 3'd3; rDin = 0;
    @(negedge clk);
    lWrEn = 0; rWrEn = 0;
    readBoth(3'd3);
    check("R11 left still owns 3", lDout, '0);
    check("R11 right still out", rDout, '1);

    // R1 reset mid-run clears ownership
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    check("R1 lDout during reset", lDout, '1);
    rstN = 1;
    readBoth(3'd3);
    check("R1 flag 3 left after reset", lDout, '1);
    check("R1 flag 3 right after reset", rDout, '1);
    doWrite(1'b0, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0);
    readBoth(3'd3);
    check("R1 no stale claim, right owns 3", rDout, '0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule